// File: doc/BRIEF.md
# SPI Nonvolatile Register Write Engine

This block is the serial front end of a small nonvolatile memory. It decodes three commands from an SPI mode-0 bus. A status write sets the two block-protect bits. A configuration read and a configuration write reach two configuration bits that sit at a fixed address. A status read reports the protect bits together with a busy flag.

A write takes effect only when chip select rises after an exact number of SCK rising edges. Chip select rising at any other point drops the command. A committed write starts a self-timed program cycle, with its length set in system clock cycles. Until that cycle ends, every command except the status read is ignored.

SCK, CSB and SI are synchronised into a single system clock domain. All decoding, the SO driver and the program timer run on that clock. The protect bits are also decoded into a protected-region base address for the array controller.

Top module: `spi_nvw_engine`

## Requirements
- R1: After reset, SO is high-impedance, the protect bits and configuration bits are 0, busy is 0 and region protection is disabled.
- R2: SI is sampled on rising SCK edges, MSB first. SO changes only after falling SCK edges, so it holds steady for the whole of every SCK high phase.
- R3: A frame with opcode 0x01 is a status write. BP1 and BP0 are the bits sampled on rising edges 12 and 13, counting from 0, which are data bits 3 and 2. The write commits only if CSB rises after exactly 16 rising edges. After 15 or 17 edges the protect bits stay unchanged.
- R4: Opcode 0x05 is a status read. It returns the byte {0,0,0,0,BP1,BP0,0,busy}, MSB first. The first bit is driven after the falling edge that follows rising edge 7. After eight bits SO returns to high-impedance.
- R5: Opcode 0x03 followed by the 16-bit address 0x0800 is a configuration read. It returns {000000,CFG1,CFG0}, driven from the falling edge that follows rising edge 23. With any other address, SO stays high-impedance.
- R6: Opcode 0x82 followed by address 0x0800 is a configuration write. CFG1 and CFG0 are the bits sampled on rising edges 28 and 29. The write commits only if CSB rises after exactly 30 rising edges and the address matched. In every other case the configuration bits stay unchanged.
- R7: A committed write raises busy for exactly PROG_CYCLES system clock cycles.
- R8: While busy is set, every opcode except 0x05 is ignored: it causes no commit and no SO drive.
- R9: Region protection decodes the protect bits as {BP1,BP0}. 00 gives no protection. 01 protects the upper quarter, with base 3/4 of the array. 10 protects the upper half, with base 1/2. 11 protects the whole array, with base 0.
- R10: An unknown opcode is ignored until CSB goes high. CSB high drives SO to high-impedance and restarts the edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the synchronisers, the decoder and the program timer |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, mode 0 |
| csb | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, high-impedance when not reading |
| bp_o | output | 2 | Block-protect bits {BP1,BP0} |
| cfg_o | output | 2 | Configuration bits {CFG1,CFG0} |
| busy_o | output | 1 | Program cycle in progress |
| prot_en_o | output | 1 | Region protection active |
| prot_base_o | output | ARRAY_AW | First protected array address |

## Verification
The bound checker watches four things on every cycle:
- the protect and configuration bits change only in the cycle when busy rises;
- neither set of bits moves during a busy period;
- every busy period lasts PROG_CYCLES cycles;
- the region decode follows the protect bits one cycle later, and SO is released while CSB is high.

Only the bench scenarios can show the parts that depend on the serial frame. These are the exact commit windows one edge either side of the target, the bit positions of the data, the address match, the serialised read bytes, and the lockout of non-status commands during a program cycle.

// File: rtl/spi_nvw_pkg.sv
package spi_nvw_pkg;
  localparam logic [7:0]  OPC_STAT_WR = 8'h01;
  localparam logic [7:0]  OPC_STAT_RD = 8'h05;
  localparam logic [7:0]  OPC_READ    = 8'h03;
  localparam logic [7:0]  OPC_CFG_WR  = 8'h82;
  localparam logic [15:0] CFG_ADDR    = 16'h0800;

  // rising-edge counts that matter to the decoder
  localparam int OPC_LAST_EDGE  = 7;
  localparam int ADDR_LAST_EDGE = 23;
  localparam int STAT_WR_EDGES  = 16;
  localparam int CFG_WR_EDGES   = 30;
  localparam int BYTE_BITS      = 8;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_STAT_WR,
    CMD_STAT_RD,
    CMD_READ,
    CMD_CFG_WR
  } cmd_e;
endpackage

// File: rtl/spi_nvw_sync.sv
module spi_nvw_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= {STAGES{RST_VAL[g]}};
      else     pipe <= {pipe[STAGES-2:0], d[g]};
    end
    assign q[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spi_nvw_frame.sv
module spi_nvw_frame
  import spi_nvw_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_q,
  input  logic       csb_q,
  input  logic       si_q,
  input  logic       busy,
  input  logic [1:0] bp,
  input  logic [1:0] cfg,
  output logic       stat_commit,
  output logic       cfg_commit,
  output logic [1:0] wdata,
  output logic       so_d,
  output logic       so_oe
);
  localparam int LEFT_W = $clog2(BYTE_BITS + 1);

  logic              sck_prev, csb_prev;
  logic [CNT_W-1:0]  edge_cnt;
  logic [15:0]       sr;
  cmd_e              cmd;
  logic              addr_ok;
  logic [7:0]        tx_sh;
  logic [LEFT_W-1:0] tx_left;

  logic        sck_rise, sck_fall, csb_rise;
  logic [15:0] sr_next;
  cmd_e        cmd_dec;

  assign sck_rise = sck_q & ~sck_prev & ~csb_q;
  assign sck_fall = ~sck_q & sck_prev & ~csb_q;
  assign csb_rise = csb_q & ~csb_prev;
  assign sr_next  = {sr[14:0], si_q};

  always_comb begin
    unique case (sr_next[7:0])
      OPC_STAT_WR: cmd_dec = CMD_STAT_WR;
      OPC_STAT_RD: cmd_dec = CMD_STAT_RD;
      OPC_READ:    cmd_dec = CMD_READ;
      OPC_CFG_WR:  cmd_dec = CMD_CFG_WR;
      default:     cmd_dec = CMD_NONE;
    endcase
    // during a program cycle only the status read survives
    if (busy && cmd_dec != CMD_STAT_RD) cmd_dec = CMD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev    <= 1'b0;
      csb_prev    <= 1'b1;
      edge_cnt    <= '0;
      sr          <= '0;
      cmd         <= CMD_NONE;
      addr_ok     <= 1'b0;
      tx_sh       <= '0;
      tx_left     <= '0;
      so_d        <= 1'b0;
      so_oe       <= 1'b0;
      stat_commit <= 1'b0;
      cfg_commit  <= 1'b0;
      wdata       <= '0;
    end else begin
      sck_prev    <= sck_q;
      csb_prev    <= csb_q;
      stat_commit <= 1'b0;
      cfg_commit  <= 1'b0;

      if (csb_rise) begin
        if (cmd == CMD_STAT_WR && edge_cnt == CNT_W'(STAT_WR_EDGES)) begin
          stat_commit <= 1'b1;
          wdata       <= sr[3:2];
        end
        if (cmd == CMD_CFG_WR && addr_ok && edge_cnt == CNT_W'(CFG_WR_EDGES)) begin
          cfg_commit <= 1'b1;
          wdata      <= sr[1:0];
        end
      end

      if (csb_q) begin
        edge_cnt <= '0;
        cmd      <= CMD_NONE;
        addr_ok  <= 1'b0;
        tx_left  <= '0;
        so_oe    <= 1'b0;
      end else begin
        if (sck_rise) begin
          sr <= sr_next;
          if (edge_cnt != '1) edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == CNT_W'(OPC_LAST_EDGE)) begin
            cmd <= cmd_dec;
            if (cmd_dec == CMD_STAT_RD) begin
              tx_sh   <= {4'b0000, bp, 1'b0, busy};
              tx_left <= LEFT_W'(BYTE_BITS);
            end
          end
          if (edge_cnt == CNT_W'(ADDR_LAST_EDGE)) begin
            addr_ok <= (sr_next == CFG_ADDR);
            if (cmd == CMD_READ && sr_next == CFG_ADDR) begin
              tx_sh   <= {6'b000000, cfg};
              tx_left <= LEFT_W'(BYTE_BITS);
            end
          end
        end
        if (sck_fall) begin
          if (tx_left != '0) begin
            so_oe   <= 1'b1;
            so_d    <= tx_sh[7];
            tx_sh   <= {tx_sh[6:0], 1'b0};
            tx_left <= tx_left - 1'b1;
          end else begin
            so_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_nvw_prog_timer.sv
module spi_nvw_prog_timer #(
  parameter int PROG_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int W = $clog2(PROG_CYCLES + 1);
  logic [W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (start)         remain <= W'(PROG_CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/spi_nvw_prot_map.sv
module spi_nvw_prot_map #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bp,
  output logic          prot_en,
  output logic [AW-1:0] prot_base
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en   <= 1'b0;
      prot_base <= '0;
    end else begin
      unique case (bp)
        2'b01:   begin prot_en <= 1'b1; prot_base <= {2'b11, {(AW-2){1'b0}}}; end
        2'b10:   begin prot_en <= 1'b1; prot_base <= {2'b10, {(AW-2){1'b0}}}; end
        2'b11:   begin prot_en <= 1'b1; prot_base <= '0; end
        default: begin prot_en <= 1'b0; prot_base <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/spi_nvw_engine.sv
module spi_nvw_engine #(
  parameter int PROG_CYCLES = 250000,
  parameter int ARRAY_AW    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck,
  input  logic                csb,
  input  logic                si,
  output logic                so,
  output logic [1:0]          bp_o,
  output logic [1:0]          cfg_o,
  output logic                busy_o,
  output logic                prot_en_o,
  output logic [ARRAY_AW-1:0] prot_base_o
);
  logic [2:0] pin_q;
  logic       stat_commit, cfg_commit;
  logic [1:0] wdata;
  logic       so_d, so_oe;

  spi_nvw_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({si, csb, sck}), .q(pin_q)
  );

  spi_nvw_frame #(.CNT_W(6)) u_frame (
    .clk(clk), .rst(rst),
    .sck_q(pin_q[0]), .csb_q(pin_q[1]), .si_q(pin_q[2]),
    .busy(busy_o), .bp(bp_o), .cfg(cfg_o),
    .stat_commit(stat_commit), .cfg_commit(cfg_commit), .wdata(wdata),
    .so_d(so_d), .so_oe(so_oe)
  );

  spi_nvw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(stat_commit | cfg_commit), .busy(busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_o  <= 2'b00;
      cfg_o <= 2'b00;
    end else begin
      if (stat_commit) bp_o  <= wdata;
      if (cfg_commit)  cfg_o <= wdata;
    end
  end

  spi_nvw_prot_map #(.AW(ARRAY_AW)) u_prot (
    .clk(clk), .rst(rst), .bp(bp_o), .prot_en(prot_en_o), .prot_base(prot_base_o)
  );

  assign so = so_oe ? so_d : 1'bz;
endmodule

// File: rtl/spi_nvw_engine_chk.sv
module spi_nvw_engine_chk #(
  parameter int PROG_CYCLES = 250000
) (
  input logic       clk,
  input logic       rst,
  input logic       csb,
  input logic       so_oe,
  input logic [1:0] bp,
  input logic [1:0] cfg,
  input logic       busy,
  input logic       prot_en
);
  logic [31:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= '0;
  end

  // R3
  bp_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> $rose(busy));

  // R6
  cfg_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> $rose(busy));

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_run == 32'(PROG_CYCLES));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(bp) && $stable(cfg)));

  // R9
  prot_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> prot_en == ($past(bp) != 2'b00));

  // R10
  so_release_chk: assert property (@(posedge clk) disable iff (rst)
    (csb && $past(csb) && $past(csb, 2) && $past(csb, 3)) |-> !so_oe);
endmodule

bind spi_nvw_engine spi_nvw_engine_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .csb(csb), .so_oe(so_oe),
  .bp(bp_o), .cfg(cfg_o), .busy(busy_o), .prot_en(prot_en_o)
);

// File: tb/spi_nvw_engine_tb.sv
module spi_nvw_engine_tb;
  localparam int PROG = 2000;
  localparam int AW   = 11;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, csb = 1'b1, si = 1'b0;
  tri1  so_w;
  logic [1:0] bp_o, cfg_o;
  logic busy_o, prot_en_o;
  logic [AW-1:0] prot_base_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [1:0] m_bp = 2'b00, m_cfg = 2'b00;

  always #10 clk = ~clk;

  spi_nvw_engine #(.PROG_CYCLES(PROG), .ARRAY_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .csb(csb), .si(si), .so(so_w),
    .bp_o(bp_o), .cfg_o(cfg_o), .busy_o(busy_o),
    .prot_en_o(prot_en_o), .prot_base_o(prot_base_o)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_byte(input logic [1:0] b, input logic bz);
    return {4'b0000, b, 1'b0, bz};
  endfunction

  function automatic logic [7:0] cfg_byte(input logic [1:0] c);
    return {6'b000000, c};
  endfunction

  function automatic logic [AW:0] prot_exp(input logic [1:0] b);
    case (b)
      2'b01:   return {1'b1, 2'b11, {(AW-2){1'b0}}};
      2'b10:   return {1'b1, 2'b10, {(AW-2){1'b0}}};
      2'b11:   return {1'b1, {AW{1'b0}}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] take(input logic [40:0] r, input int s);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[7-k] = r[s+k];
    return b;
  endfunction

  // tx is left aligned: bit sent on rising edge i is tx[39-i]
  // rx[i] is SO just before rising edge i; mism counts SO changes inside high phases
  task automatic frame(input logic [39:0] tx, input int n, output logic [40:0] rx, output int mism);
    logic hi;
    rx = '1; mism = 0;
    csb = 1'b0;
    wclk(HALF);
    for (int i = 0; i < n; i++) begin
      si = tx[39-i];
      wclk(HALF);
      rx[i] = so_w;
      sck = 1'b1;
      wclk(HALF);
      hi = so_w;
      if (hi !== rx[i]) mism++;
      sck = 1'b0;
    end
    wclk(HALF);
    rx[n] = so_w;
    csb = 1'b1;
    wclk(2*HALF);
  endtask

  task automatic stat_wr(input logic [1:0] b, input int n, input logic [7:0] junk);
    logic [40:0] rx; int m;
    frame({8'h01, junk[7:4], b, junk[1:0], 24'h5a5a5a}, n, rx, m);
  endtask

  task automatic cfg_wr(input logic [1:0] c, input logic [15:0] a, input int n);
    logic [40:0] rx; int m;
    frame({8'h82, a, 4'b1010, c, 2'b11, 8'h3c}, n, rx, m);
  endtask

  task automatic stat_rd(input logic [1:0] b, input logic bz, input string req);
    logic [40:0] rx; int m;
    frame({8'h05, 32'h0}, 17, rx, m);
    chk(req, "status byte", take(rx, 8), stat_byte(b, bz));
    chk("R10", "SO idle before status data", rx[7], 1'b1);
    chk("R4", "SO released after status byte", rx[16], 1'b1);
    chk("R2", "SO steady in SCK high", m, 0);
  endtask

  task automatic cfg_rd(input logic [1:0] c);
    logic [40:0] rx; int m;
    frame({8'h03, 16'h0800, 16'h0}, 33, rx, m);
    chk("R5", "cfg byte", take(rx, 24), cfg_byte(c));
    chk("R5", "SO idle before cfg data", rx[23], 1'b1);
    chk("R5", "SO released after cfg byte", rx[32], 1'b1);
    chk("R2", "SO steady in SCK high (cfg read)", m, 0);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy_o && g < 4*PROG) begin wclk(1); g++; end
    wclk(4);
  endtask

  task automatic check_state(input string req);
    chk(req, "bp_o", bp_o, m_bp);
    chk(req, "cfg_o", cfg_o, m_cfg);
    chk("R9", "prot decode", {prot_en_o, prot_base_o}, prot_exp(m_bp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R7 watchdog expired actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [40:0] rx; int m, len, g;
    void'($urandom(32'd20240611));
    wclk(5);
    rst = 1'b0;
    wclk(3);
    // R1 reset state
    chk("R1", "SO idle", so_w, 1'b1);
    chk("R1", "bp", bp_o, 2'b00);
    chk("R1", "cfg", cfg_o, 2'b00);
    chk("R1", "busy", busy_o, 1'b0);
    chk("R1", "prot_en", prot_en_o, 1'b0);

    stat_rd(2'b00, 1'b0, "R4");

    // R3 window misses: 15 and 17 edges
    stat_wr(2'b11, 15, 8'h00);
    chk("R3", "no commit at 15 edges busy", busy_o, 1'b0);
    chk("R3", "bp unchanged at 15 edges", bp_o, 2'b00);
    stat_wr(2'b11, 17, 8'hff);
    chk("R3", "no commit at 17 edges busy", busy_o, 1'b0);
    chk("R3", "bp unchanged at 17 edges", bp_o, 2'b00);

    // R3/R7 commit and busy length
    stat_wr(2'b10, 16, 8'hf3);
    m_bp = 2'b10;
    g = 0;
    len = 0;
    while (busy_o) begin len++; wclk(1); g++; if (g > 4*PROG) break; end
    chk("R7", "busy length (remaining after frame tail)", (len > PROG - 200 && len <= PROG), 1'b1);
    wclk(3);
    check_state("R3");

    // exact busy length on a fresh commit, counted from its rise
    csb = 1'b0; wclk(HALF);
    for (int i = 0; i < 16; i++) begin
      si = (i == 12) ? 1'b0 : (i == 13) ? 1'b1 : (i == 7) ? 1'b1 : 1'b0;
      wclk(HALF); sck = 1'b1; wclk(HALF); sck = 1'b0;
    end
    wclk(HALF);
    csb = 1'b1;
    m_bp = 2'b01;
    g = 0;
    while (!busy_o && g < 50) begin wclk(1); g++; end
    len = 0;
    while (busy_o && len < 4*PROG) begin wclk(1); len++; end
    chk("R7", "busy length exact", len, PROG);
    wclk(3);
    check_state("R3");

    // R8 lockout during busy
    stat_wr(2'b11, 16, 8'h00);
    m_bp = 2'b11;
    wclk(4);
    chk("R7", "busy after commit", busy_o, 1'b1);
    stat_rd(2'b11, 1'b1, "R8");
    stat_wr(2'b00, 16, 8'h00);
    cfg_wr(2'b11, 16'h0800, 30);
    frame({8'h03, 16'h0800, 16'h0}, 33, rx, m);
    chk("R8", "cfg read ignored while busy", rx, {41{1'b1}});
    wait_idle();
    check_state("R8");

    // R6 configuration write windows and address
    cfg_wr(2'b10, 16'h0800, 29);
    cfg_wr(2'b10, 16'h0800, 31);
    cfg_wr(2'b10, 16'h0801, 30);
    chk("R6", "no cfg commit busy", busy_o, 1'b0);
    check_state("R6");
    cfg_wr(2'b10, 16'h0800, 30);
    m_cfg = 2'b10;
    wait_idle();
    check_state("R6");
    cfg_rd(2'b10);

    // R5 wrong address read
    frame({8'h03, 16'h0900, 16'h0}, 33, rx, m);
    chk("R5", "wrong address read idle", rx, {41{1'b1}});

    // R10 unknown opcode followed by a status-write-like pattern
    frame({8'hab, 8'h01, 8'h00, 16'h0}, 16, rx, m);
    chk("R10", "unknown opcode SO idle", rx, {41{1'b1}});
    chk("R10", "unknown opcode no busy", busy_o, 1'b0);
    check_state("R10");

    // R9 every protect code
    for (int b = 0; b < 4; b++) begin
      stat_wr(2'(b), 16, 8'(b * 37));
      m_bp = 2'(b);
      wait_idle();
      check_state("R9");
    end

    // random mix
    for (int it = 0; it < 24; it++) begin
      int kind, n, off;
      logic [1:0] d;
      logic [15:0] a;
      kind = int'($urandom_range(0, 2));
      off  = int'($urandom_range(0, 2)) - 1;
      d    = 2'($urandom);
      if (kind == 0) begin
        n = 16 + off;
        stat_wr(d, n, 8'($urandom));
        if (n == 16) m_bp = d;
        wait_idle();
        check_state("R3");
      end else if (kind == 1) begin
        n = 30 + off;
        a = ($urandom_range(0, 3) == 0) ? 16'h0810 : 16'h0800;
        cfg_wr(d, a, n);
        if (n == 30 && a == 16'h0800) m_cfg = d;
        wait_idle();
        check_state("R6");
      end else begin
        stat_rd(m_bp, 1'b0, "R4");
        cfg_rd(m_cfg);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule